// File: doc/BRIEF.md
# Set-Associative Data Cache Controller

This block sits between a processor load/store port and the memory side of a chip. It keeps tag, valid and dirty state for a four-way set-associative data cache of 64 sets with 32-byte lines (eight 32-bit words), which gives 8 KB. The tag and data arrays are held in registers and read in a single cycle. Each request carries a virtual address, which indexes the cache and matches the virtual tag, and the physical address already translated for it. It also carries two attribute bits: cacheable and bufferable. A line stores both tags, so an eviction is addressed from the stored physical tag alone and needs no translation.

Read misses in cacheable regions refill a whole line. The refill starts at the requested word and wraps around the line, and the load returns on the first data beat. Stores never allocate a line. A write-back hit only marks one of two half-line dirty bits. A write-through hit also sends the word to the write buffer. Every other store goes to the write buffer. A victim is chosen round-robin among the ways left free by a per-way lockdown mask. When the mask locks all four ways, a miss is serviced as an uncached single-word read. Maintenance commands invalidate one line by virtual address or the whole cache, and they do not write anything back.

The processor holds each request stable until `req_ready`. The low 11 bits of `req_paddr` must equal those of `req_vaddr`. Address fields are: word in line at bits [4:2], set at bits [10:5], tag at bits [31:11].

Top module: `dcache_ctrl`

## Requirements
- R1: After reset every line is invalid, `mnt_ready` is high and no memory read, write-back or write-buffer request is raised, so the first cacheable load misses.
- R2: A cacheable load miss issues one line read (`mem_rd_line`=1) at the physical address of the requested word. The returned beats fill words in the order requested word, then +1 modulo 8. The load completes with `resp_valid` on the first beat, and later loads to that line hit with no memory read.
- R3: A store hit with cacheable=1 and bufferable=1 (write-back) updates the cached word, sets the dirty bit of its half (word bit 2) and raises no write-buffer request.
- R4: A store hit with cacheable=1 and bufferable=0 (write-through) updates the cached word, pushes the word to the write buffer at its physical address, and leaves the line clean.
- R5: A cacheable store miss does not allocate a line. It is pushed to the write buffer, and a later load to that address still misses.
- R6: With cacheable=0 a load is a single-word read (`mem_rd_line`=0) and a store is a write-buffer push. Neither reads nor changes the cache contents.
- R7: Evicting a valid line writes back only its dirty halves: words 0-3 when the lower half is dirty, words 4-7 when the upper half is dirty, in ascending word order. A clean victim causes no write-back.
- R8: Write-back addresses and refill addresses use the physical tag supplied with the access that filled or requested the line, never the virtual tag.
- R9: The victim is the first unlocked way at or after a round-robin pointer, which moves to the way after each completed fill. A set lockdown bit w (`lock_din[w]`) keeps way w from being chosen.
- R10: With all four lockdown bits set, a cacheable load miss is serviced as an uncached single-word read with no allocation, while hits in locked ways are still served from the cache.
- R11: An invalidate-line command (`mnt_all`=0) clears the line whose virtual tag and set match `mnt_vaddr` and leaves the other ways of the set intact.
- R12: An invalidate-all command (`mnt_all`=1) clears every line, including dirty ones, with no write-back.
- R13: At most one way of a set matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address (index and virtual tag) |
| req_paddr | input | 32 | Translated physical byte address |
| req_wdata | input | 32 | Store data |
| req_cacheable | input | 1 | Cacheable attribute |
| req_bufferable | input | 1 | Bufferable attribute (1 = write-back when cacheable) |
| req_ready | output | 1 | Access accepted this cycle |
| resp_valid | output | 1 | Load data valid this cycle |
| resp_rdata | output | 32 | Load data |
| lock_we | input | 1 | Write the lockdown mask |
| lock_din | input | 4 | New lockdown mask, bit w locks way w |
| mnt_valid | input | 1 | Maintenance command |
| mnt_all | input | 1 | 1 = invalidate all, 0 = invalidate one line |
| mnt_vaddr | input | 32 | Virtual address for the line invalidate |
| mnt_ready | output | 1 | Maintenance command accepted |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_line | output | 1 | 1 = eight-beat wrapping line read, 0 = single word |
| mem_rd_addr | output | 32 | Physical address of the first word |
| mem_rd_ready | input | 1 | Memory read request accepted |
| mem_rd_dvalid | input | 1 | Read data beat valid |
| mem_rd_data | input | 32 | Read data beat |
| wb_valid | output | 1 | Eviction write-back word valid |
| wb_addr | output | 32 | Physical address of the write-back word |
| wb_data | output | 32 | Write-back data |
| wb_ready | input | 1 | Write-back word accepted |
| wbuf_valid | output | 1 | Write-buffer store request |
| wbuf_addr | output | 32 | Physical store address |
| wbuf_data | output | 32 | Store data |
| wbuf_ready | input | 1 | Write buffer accepts the store |

## Verification
The bench loads from the middle of a line and then from an earlier word of that line. A design that filled from word 0, or that held the load until the line was complete, would return the wrong word or fetch again. It evicts lines with only the lower half dirty, only the upper half dirty, and both halves dirty, with physical tags that differ from the virtual ones. A single dirty bit, a missing skip of the clean half, or a virtual eviction address would show up as wrong write-back word counts or addresses. It runs fills under partial and full lockdown. Ignoring the mask would let a refill displace a line that must survive, and a full lock that still allocated would turn a repeated load into a hit. Invalidating one line must spare its neighbour, and invalidate-all on a dirty line must raise no write-back.

// File: rtl/dcache_ctrl.sv
module dcache_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WAYS = 4,
  parameter int SETS = 64,
  parameter int LINE_WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] req_paddr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_cacheable,
  input  logic          req_bufferable,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_rdata,
  input  logic          lock_we,
  input  logic [WAYS-1:0] lock_din,
  input  logic          mnt_valid,
  input  logic          mnt_all,
  input  logic [AW-1:0] mnt_vaddr,
  output logic          mnt_ready,
  output logic          mem_rd_valid,
  output logic          mem_rd_line,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ready,
  input  logic          mem_rd_dvalid,
  input  logic [DW-1:0] mem_rd_data,
  output logic          wb_valid,
  output logic [AW-1:0] wb_addr,
  output logic [DW-1:0] wb_data,
  input  logic          wb_ready,
  output logic          wbuf_valid,
  output logic [AW-1:0] wbuf_addr,
  output logic [DW-1:0] wbuf_data,
  input  logic          wbuf_ready
);

  localparam int OFFW = $clog2(LINE_WORDS);
  localparam int IDXW = $clog2(SETS);
  localparam int WW   = $clog2(WAYS);
  localparam int TW   = AW - IDXW - OFFW - 2;
  localparam logic [OFFW-1:0] LAST_W    = OFFW'(LINE_WORDS - 1);
  localparam logic [OFFW-1:0] LO_LAST_W = OFFW'(LINE_WORDS / 2 - 1);
  localparam logic [OFFW-1:0] HI_FIRST  = OFFW'(LINE_WORDS / 2);

  typedef enum logic [2:0] {S_IDLE, S_EVICT, S_FREQ, S_FDATA, S_UREQ, S_UDATA} st_t;
  st_t st;

  logic [WAYS-1:0] valid_q [SETS];
  logic [1:0]      dirty_q [SETS][WAYS];
  logic [TW-1:0]   vtag_q  [SETS][WAYS];
  logic [TW-1:0]   ptag_q  [SETS][WAYS];
  logic [DW-1:0]   data_q  [SETS*WAYS*LINE_WORDS];
  logic [WAYS-1:0] lock_q;
  logic [WW-1:0]   rr_q;

  logic [IDXW-1:0] cap_idx;
  logic [OFFW-1:0] cap_word, wcnt, fcnt;
  logic [TW-1:0]   cap_vtag, cap_ptag, cap_vptag;
  logic [WW-1:0]   cap_way;
  logic [1:0]      cap_vdirty;

  wire [IDXW-1:0] r_idx  = req_vaddr[OFFW+2 +: IDXW];
  wire [OFFW-1:0] r_word = req_vaddr[2 +: OFFW];
  wire [TW-1:0]   r_vtag = req_vaddr[AW-1 -: TW];
  wire [TW-1:0]   r_ptag = req_paddr[AW-1 -: TW];
  wire [IDXW-1:0] m_idx  = mnt_vaddr[OFFW+2 +: IDXW];
  wire [TW-1:0]   m_vtag = mnt_vaddr[AW-1 -: TW];
  logic unused_lowbits;
  assign unused_lowbits = ^{req_vaddr[1:0], mnt_vaddr[OFFW+1:0]};

  logic [WAYS-1:0] hit_vec;
  logic [WW-1:0]   hit_way, vict_way;
  logic            vict_ok;
  logic [WW-1:0]   cand;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_q[r_idx][w] && (vtag_q[r_idx][w] == r_vtag);
      if (hit_vec[w]) hit_way = WW'(w);
    end
  end

  always_comb begin
    vict_way = '0;
    vict_ok  = 1'b0;
    cand     = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      cand = rr_q + WW'(i);
      if (!lock_q[cand]) begin
        vict_way = cand;
        vict_ok  = 1'b1;
      end
    end
  end

  wire idle_go   = (st == S_IDLE) && !mnt_valid && req_valid;
  wire hit       = req_cacheable && |hit_vec;
  wire wr_hit_wb = idle_go && req_write && hit && req_bufferable;
  wire wr_push   = idle_go && req_write && !(hit && req_bufferable);
  wire rd_hit    = idle_go && !req_write && hit;
  wire rd_fill   = idle_go && !req_write && !hit && req_cacheable && vict_ok;
  wire rd_unc    = idle_go && !req_write && !hit && !(req_cacheable && vict_ok);
  wire first_bt  = (st == S_FDATA) && mem_rd_dvalid && (fcnt == '0);
  wire unc_bt    = (st == S_UDATA) && mem_rd_dvalid;
  wire fill_done = (st == S_FDATA) && mem_rd_dvalid && (fcnt == LAST_W);
  wire ev_last   = (wcnt == LAST_W) || ((wcnt == LO_LAST_W) && !cap_vdirty[1]);
  wire [OFFW-1:0] fill_word = cap_word + fcnt;

  assign req_ready   = wr_hit_wb || (wr_push && wbuf_ready) || rd_hit || first_bt || unc_bt;
  assign resp_valid  = rd_hit || first_bt || unc_bt;
  assign resp_rdata  = rd_hit ? data_q[{r_idx, hit_way, r_word}] : mem_rd_data;
  assign wbuf_valid  = wr_push;
  assign wbuf_addr   = req_paddr;
  assign wbuf_data   = req_wdata;
  assign mem_rd_valid = (st == S_FREQ) || (st == S_UREQ);
  assign mem_rd_line = (st == S_FREQ);
  assign mem_rd_addr = {cap_ptag, cap_idx, cap_word, 2'b00};
  assign wb_valid    = (st == S_EVICT);
  assign wb_addr     = {cap_vptag, cap_idx, wcnt, 2'b00};
  assign wb_data     = data_q[{cap_idx, cap_way, wcnt}];
  assign mnt_ready   = (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (wr_hit_wb || (wr_push && wbuf_ready && hit))
      data_q[{r_idx, hit_way, r_word}] <= req_wdata;
    if ((st == S_FDATA) && mem_rd_dvalid)
      data_q[{cap_idx, cap_way, fill_word}] <= mem_rd_data;
    if (fill_done) begin
      vtag_q[cap_idx][cap_way] <= cap_vtag;
      ptag_q[cap_idx][cap_way] <= cap_ptag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lock_q <= '0;
      rr_q <= '0;
      cap_idx <= '0; cap_word <= '0; cap_vtag <= '0; cap_ptag <= '0;
      cap_vptag <= '0; cap_way <= '0; cap_vdirty <= '0;
      wcnt <= '0; fcnt <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) dirty_q[s][w] <= '0;
      end
    end else begin
      if (lock_we) lock_q <= lock_din;
      case (st)
        S_IDLE: begin
          if (mnt_valid) begin
            if (mnt_all) begin
              for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            end else begin
              for (int w = 0; w < WAYS; w++)
                if (valid_q[m_idx][w] && (vtag_q[m_idx][w] == m_vtag)) valid_q[m_idx][w] <= 1'b0;
            end
          end else begin
            if (wr_hit_wb) dirty_q[r_idx][hit_way][r_word[OFFW-1]] <= 1'b1;
            if (rd_fill || rd_unc) begin
              cap_idx  <= r_idx;
              cap_word <= r_word;
              cap_vtag <= r_vtag;
              cap_ptag <= r_ptag;
            end
            if (rd_fill) begin
              cap_way    <= vict_way;
              cap_vptag  <= ptag_q[r_idx][vict_way];
              cap_vdirty <= dirty_q[r_idx][vict_way];
              valid_q[r_idx][vict_way] <= 1'b0;
              fcnt <= '0;
              if (valid_q[r_idx][vict_way] && |dirty_q[r_idx][vict_way]) begin
                st   <= S_EVICT;
                wcnt <= dirty_q[r_idx][vict_way][0] ? '0 : HI_FIRST;
              end else begin
                st <= S_FREQ;
              end
            end
            if (rd_unc) st <= S_UREQ;
          end
        end
        S_EVICT: if (wb_ready) begin
          if (ev_last) st <= S_FREQ;
          else wcnt <= wcnt + OFFW'(1);
        end
        S_FREQ: if (mem_rd_ready) st <= S_FDATA;
        S_FDATA: if (mem_rd_dvalid) begin
          fcnt <= fcnt + OFFW'(1);
          if (fill_done) begin
            valid_q[cap_idx][cap_way] <= 1'b1;
            dirty_q[cap_idx][cap_way] <= '0;
            rr_q <= cap_way + WW'(1);
            st <= S_IDLE;
          end
        end
        S_UREQ: if (mem_rd_ready) st <= S_UDATA;
        S_UDATA: if (mem_rd_dvalid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r13_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r7_only_dirty_half: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> cap_vdirty[wcnt[OFFW-1]]);
  a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
  a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  a_r2_valid_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> valid_q[cap_idx][cap_way]);
  a_r12_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && mnt_valid && mnt_all |=> (valid_q[0] == '0) && (valid_q[SETS-1] == '0));

endmodule

// File: tb/dcache_ctrl_tb.sv
module dcache_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_cacheable = 0, req_bufferable = 0;
  logic [31:0] req_vaddr = 0, req_paddr = 0, req_wdata = 0;
  logic req_ready, resp_valid; logic [31:0] resp_rdata;
  logic lock_we = 0; logic [3:0] lock_din = 0;
  logic mnt_valid = 0, mnt_all = 0; logic [31:0] mnt_vaddr = 0; logic mnt_ready;
  logic mem_rd_valid, mem_rd_line; logic [31:0] mem_rd_addr;
  logic mem_rd_ready = 0, mem_rd_dvalid = 0; logic [31:0] mem_rd_data = 0;
  logic wb_valid; logic [31:0] wb_addr, wb_data; logic wb_ready = 1;
  logic wbuf_valid; logic [31:0] wbuf_addr, wbuf_data; logic wbuf_ready = 1;

  dcache_ctrl u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int rd_n = 0, wb_n = 0, wbuf_n = 0;
  logic [31:0] last_rd_addr, last_wbuf_addr, last_wbuf_data;
  logic last_rd_line;
  logic [31:0] wb_alog [64];
  logic [31:0] wb_dlog [64];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:2], 2'b01, ~a[17:2]};
  endfunction
  function automatic logic [31:0] A(input logic [20:0] t, input logic [5:0] s, input logic [2:0] w);
    return {t, s, w, 2'b00};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_rd_valid && mem_rd_ready) begin
      rd_n <= rd_n + 1; last_rd_addr <= mem_rd_addr; last_rd_line <= mem_rd_line;
    end
    if (wb_valid && wb_ready) begin
      wb_alog[wb_n % 64] <= wb_addr; wb_dlog[wb_n % 64] <= wb_data; wb_n <= wb_n + 1;
    end
    if (wbuf_valid && wbuf_ready) begin
      wbuf_n <= wbuf_n + 1; last_wbuf_addr <= wbuf_addr; last_wbuf_data <= wbuf_data;
    end
  end

  always begin
    @(negedge clk);
    if (mem_rd_valid) begin
      logic [31:0] a; logic ln; logic [2:0] w;
      a = mem_rd_addr; ln = mem_rd_line;
      mem_rd_ready = 1; @(negedge clk); mem_rd_ready = 0;
      for (int i = 0; i < (ln ? 8 : 1); i++) begin
        w = a[4:2] + 3'(i);
        mem_rd_dvalid = 1; mem_rd_data = pat({a[31:5], w, 2'b00});
        @(negedge clk);
      end
      mem_rd_dvalid = 0;
    end
  end

  logic [31:0] rdat; logic rvld;
  task automatic acc(input logic wr, input logic [31:0] va, input logic [31:0] pa,
                     input logic [31:0] wd, input logic c, input logic b);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_vaddr = va; req_paddr = pa; req_wdata = wd;
    req_cacheable = c; req_bufferable = b;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    rdat = resp_rdata; rvld = resp_valid;
    @(posedge clk); #1;
    req_valid = 0;
  endtask
  task automatic rd(input logic [31:0] a, input logic c);
    acc(1'b0, a, a, 32'h0, c, 1'b1);
  endtask
  task automatic setlock(input logic [3:0] m);
    @(negedge clk); lock_we = 1; lock_din = m; @(posedge clk); #1; lock_we = 0;
  endtask
  task automatic mnt(input logic all, input logic [31:0] a);
    @(negedge clk); mnt_valid = 1; mnt_all = all; mnt_vaddr = a;
    #1; while (!mnt_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1; mnt_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 mnt_ready", 32'(mnt_ready), 1);
    chk("R1 mem_rd_valid", 32'(mem_rd_valid), 0);
    chk("R1 wb_valid", 32'(wb_valid), 0);
    chk("R1 wbuf_valid", 32'(wbuf_valid), 0);
  endtask

  task automatic t_fill;
    int r0 = rd_n;
    acc(0, A(1,3,5), A(21'h1234,3,5), 0, 1, 1);
    chk("R1 first load misses", rd_n - r0, 1);
    chk("R2 resp_valid", 32'(rvld), 1);
    chk("R2 critical word data", rdat, pat(A(21'h1234,3,5)));
    chk("R8 fill physical addr", last_rd_addr, A(21'h1234,3,5));
    chk("R2 line read", 32'(last_rd_line), 1);
    acc(0, A(1,3,2), A(21'h1234,3,2), 0, 1, 1);
    chk("R2 wrapped word hit", rdat, pat(A(21'h1234,3,2)));
    chk("R2 no refetch", rd_n - r0, 1);
  endtask

  task automatic t_wbhit;
    int f0 = wbuf_n, r0 = rd_n;
    acc(1, A(1,3,1), A(21'h1234,3,1), 32'hDEAD0001, 1, 1);
    chk("R3 no wbuf push", wbuf_n - f0, 0);
    acc(0, A(1,3,1), A(21'h1234,3,1), 0, 1, 1);
    chk("R3 store hit data", rdat, 32'hDEAD0001);
    chk("R3 no mem read", rd_n - r0, 0);
  endtask

  task automatic t_evict;
    int b0;
    rd(A(2,3,0), 1); rd(A(3,3,0), 1); rd(A(4,3,0), 1);
    b0 = wb_n;
    rd(A(5,3,0), 1);
    chk("R7 lower half count", wb_n - b0, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R8 wb phys addr", wb_alog[b0+i], A(21'h1234,3,3'(i)));
      chk("R7 wb data", wb_dlog[b0+i], (i == 1) ? 32'hDEAD0001 : pat(A(21'h1234,3,3'(i))));
    end
  endtask

  task automatic t_wt;
    int f0 = wbuf_n, r0 = rd_n, b0;
    acc(1, A(2,3,3), A(2,3,3), 32'hC0DE0002, 1, 0);
    chk("R4 wbuf push", wbuf_n - f0, 1);
    chk("R4 wbuf addr", last_wbuf_addr, A(2,3,3));
    chk("R4 wbuf data", last_wbuf_data, 32'hC0DE0002);
    rd(A(2,3,3), 1);
    chk("R4 line updated", rdat, 32'hC0DE0002);
    chk("R4 hit no read", rd_n - r0, 0);
    b0 = wb_n;
    rd(A(6,3,0), 1);
    chk("R4 clean eviction no wb", wb_n - b0, 0);
    r0 = rd_n;
    rd(A(2,3,3), 1);
    chk("R9 round robin evicted way1", rd_n - r0, 1);
  endtask

  task automatic t_wmiss;
    int f0 = wbuf_n, r0 = rd_n;
    acc(1, A(9,7,0), A(9,7,0), 32'h5A5A0003, 1, 1);
    chk("R5 miss to wbuf", wbuf_n - f0, 1);
    chk("R5 wbuf addr", last_wbuf_addr, A(9,7,0));
    rd(A(9,7,0), 1);
    chk("R5 no allocation", rd_n - r0, 1);
    chk("R5 memory data", rdat, pat(A(9,7,0)));
  endtask

  task automatic t_unc;
    int f0 = wbuf_n, r0;
    acc(1, A(5,3,0), A(5,3,0), 32'hBEEF0004, 1, 1);
    chk("R3 wb hit no push", wbuf_n - f0, 0);
    r0 = rd_n;
    rd(A(5,3,0), 0);
    chk("R6 single read", rd_n - r0, 1);
    chk("R6 single flag", 32'(last_rd_line), 0);
    chk("R6 bypass data", rdat, pat(A(5,3,0)));
    acc(1, A(5,3,0), A(5,3,0), 32'h0BAD0005, 0, 0);
    chk("R6 store to wbuf", wbuf_n - f0, 1);
    r0 = rd_n;
    rd(A(5,3,0), 1);
    chk("R6 cache untouched", rdat, 32'hBEEF0004);
    chk("R6 hit after bypass", rd_n - r0, 0);
  endtask

  task automatic t_lock;
    int r0;
    setlock(4'b0111);
    rd(A(16,20,0), 1); rd(A(17,20,0), 1);
    r0 = rd_n;
    rd(A(16,20,0), 1);
    chk("R9 only unlocked way used", rd_n - r0, 1);
  endtask

  task automatic t_alllock;
    int r0;
    setlock(4'b1111);
    r0 = rd_n;
    rd(A(18,21,4), 1);
    chk("R10 uncached read", rd_n - r0, 1);
    chk("R10 single flag", 32'(last_rd_line), 0);
    chk("R10 data", rdat, pat(A(18,21,4)));
    rd(A(18,21,4), 1);
    chk("R10 no allocation", rd_n - r0, 2);
    rd(A(16,20,0), 1);
    chk("R10 locked hit served", rd_n - r0, 2);
  endtask

  task automatic t_invline;
    int r0;
    setlock(4'b0000);
    rd(A(32,22,0), 1); rd(A(33,22,0), 1);
    mnt(0, A(32,22,0));
    r0 = rd_n;
    rd(A(33,22,0), 1);
    chk("R11 neighbour kept", rd_n - r0, 0);
    rd(A(32,22,0), 1);
    chk("R11 line cleared", rd_n - r0, 1);
  endtask

  task automatic t_halves;
    int b0;
    setlock(4'b0111);
    rd(A(48,30,0), 1);
    acc(1, A(48,30,6), A(48,30,6), 32'hAA000006, 1, 1);
    b0 = wb_n;
    rd(A(49,30,0), 1);
    chk("R7 upper half count", wb_n - b0, 4);
    for (int i = 0; i < 4; i++)
      chk("R7 upper addr", wb_alog[b0+i], A(48,30,3'(i+4)));
    chk("R7 upper dirty word", wb_dlog[b0+2], 32'hAA000006);
    acc(1, A(49,30,0), A(49,30,0), 32'hBB000000, 1, 1);
    acc(1, A(49,30,7), A(49,30,7), 32'hBB000007, 1, 1);
    b0 = wb_n;
    rd(A(50,30,0), 1);
    chk("R7 both halves count", wb_n - b0, 8);
    chk("R7 first word", wb_dlog[b0], 32'hBB000000);
    chk("R7 last word", wb_dlog[b0+7], 32'hBB000007);
    chk("R7 last addr", wb_alog[b0+7], A(49,30,7));
  endtask

  task automatic t_invall;
    int b0, r0;
    acc(1, A(50,30,2), A(50,30,2), 32'hCC000002, 1, 1);
    mnt(1, 0);
    b0 = wb_n; r0 = rd_n;
    rd(A(51,30,0), 1);
    chk("R12 no write-back", wb_n - b0, 0);
    rd(A(33,22,0), 1);
    chk("R12 all lines cleared", rd_n - r0, 2);
    setlock(4'b0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset; t_fill; t_wbhit; t_evict; t_wt; t_wmiss; t_unc;
    t_lock; t_alllock; t_invline; t_halves; t_invall;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule